// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a synchronous host and an asynchronous DRAM whose row and column addresses share one set of address pins. A host request gives a flat word address, a read/write flag and write data. The controller splits the address into a row part and a column part. It puts the row part on the pins and pulls the row strobe low. It then puts the column part on the pins and pulses the column strobe. It acknowledges the request with a single-cycle pulse, and for reads it returns the captured data word with that pulse.

After an access the row stays open. A later request to the same row needs only a new column strobe pulse. A request to another row closes the open row, waits out the precharge time and opens the new row. A separate refresh block can ask for the row to be closed. It sees through a status output when the DRAM sits precharged and unused. Each analog limit is a nanosecond parameter, and elaboration turns it into a whole number of clock cycles by rounding up at the clock period. Writes use early-write timing, so the DRAM's output enable stays inactive and the data pins carry only the controller's data.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: `host_addr[ROW_W+COL_W-1:COL_W]` is the row and `host_addr[COL_W-1:0]` is the column, each driven zero-extended on `dram_addr`. The row address is stable for at least one cycle before `dram_ras_n` falls and is held for at least T_RCD cycles (3 at defaults) after the fall. The column address is stable for at least one cycle before `dram_cas_n` falls and is held while it is low.
- R2: Every request gets exactly one `host_ack` pulse, one cycle wide. For a read, `host_rdata` at the pulse is the DRAM data sampled at a clock edge where the column strobe has been low for at least T_CASL cycles (2) and the row strobe for at least T_RAC cycles (6).
- R3: `dram_ras_n` stays high for at least T_RP cycles (4) between two low periods, and each low period lasts at least T_RAS_MIN cycles (6).
- R4: A request to the row that is already open produces a column strobe pulse and no row strobe edge. The column strobe only falls while `dram_ras_n` is low.
- R5: Between two column strobe pulses, `dram_cas_n` stays high for at least T_CP cycles (1), and successive falls are at least T_PC cycles (4) apart.
- R6: A request to a different row raises `dram_ras_n`, precharges, and opens the new row with a fresh row address.
- R7: `dram_ras_n` is never low for more than T_RAS_MAX cycles (1250). A row left open with no requests is closed before that limit.
- R8: For a write, `dram_we_n` is low for at least one cycle before `dram_cas_n` falls. `dram_oe_n` stays high, and `dram_dq_oe` is high with the write data on `dram_dq_out` when the column strobe falls.
- R9: For a read, `dram_we_n` is high before the column strobe falls, and `dram_dq_oe` is low.
- R10: While `close_req` is high, an open row is closed and `idle` rises once precharge is done. While `close_req` and `idle` are both high, no row is opened and host requests wait. `idle` is low while a row is open.
- R11: During reset all four strobes are high (inactive), `dram_dq_oe` and `host_ack` are low, and `idle` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Request valid; held with its fields until the acknowledge |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ROW_W+COL_W | Word address, row part in the upper bits |
| host_wdata | input | DQ_W | Write data |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | DQ_W | Read data, valid with the acknowledge |
| close_req | input | 1 | Refresh block asks for the row to be closed and held |
| idle | output | 1 | DRAM precharged and no access in progress |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed address pins |
| dram_dq_in | input | DQ_W | Data from the DRAM |
| dram_dq_out | output | DQ_W | Data to the DRAM |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |

## Verification
The bench's DRAM model returns the inverted word until both the column-strobe and row-strobe access windows have elapsed. A controller that samples one cycle early therefore returns corrupted read data. Runs of same-row accesses are checked by counting row strobe falls: a controller that reopens the row on every access shows extra falls, and one that ignores the row compare returns data from the wrong row. The model also measures precharge, strobe spacing, row hold and maximum row-open time, so a shortened counter shows up as a timing violation. The bench also holds a request back while the refresh block owns the DRAM, and leaves a row idle past its time limit.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RSET,
        ST_RCD,
        ST_CSET,
        ST_CAS,
        ST_CPRE,
        ST_OPEN,
        ST_PRE
    } fpm_state_e;

    // Nanosecond limit to clock cycles, rounded up, never below one cycle.
    function automatic int ns2cyc(input int ns, input int clk_ps);
        int c;
        c = (ns * 1000 + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fpm_addr_path.sv
module fpm_addr_path #(
    parameter int ROW_W = 13,
    parameter int COL_W = 11,
    parameter int DQ_W  = 4,
    parameter int PA_W  = 13
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   accept,
    input  logic                   host_we,
    input  logic [ROW_W+COL_W-1:0] host_addr,
    input  logic [DQ_W-1:0]        host_wdata,
    input  logic                   sel_col,
    input  logic                   drive_dq,
    output logic                   row_hit,
    output logic                   op_we,
    output logic [PA_W-1:0]        dram_addr,
    output logic [DQ_W-1:0]        dram_dq_out,
    output logic                   dram_dq_oe
);
    localparam int HA_W = ROW_W + COL_W;

    typedef struct packed {
        logic             we;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic [DQ_W-1:0]  wdata;
    } acc_t;

    acc_t cur;
    logic [PA_W-1:0] row_pad;
    logic [PA_W-1:0] col_pad;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (accept) begin
            cur <= '{we: host_we,
                     row: host_addr[HA_W-1:COL_W],
                     col: host_addr[COL_W-1:0],
                     wdata: host_wdata};
        end
    end

    generate
        if (PA_W > ROW_W) begin : g_row_pad
            assign row_pad = {{(PA_W-ROW_W){1'b0}}, cur.row};
        end else begin : g_row_fit
            assign row_pad = cur.row;
        end
        if (PA_W > COL_W) begin : g_col_pad
            assign col_pad = {{(PA_W-COL_W){1'b0}}, cur.col};
        end else begin : g_col_fit
            assign col_pad = cur.col;
        end
    endgenerate

    assign row_hit     = (host_addr[HA_W-1:COL_W] == cur.row);
    assign op_we       = cur.we;
    assign dram_addr   = sel_col ? col_pad : row_pad;
    assign dram_dq_out = cur.wdata;
    assign dram_dq_oe  = drive_dq;

    // R1: column address held steady while the column phase lasts
    a_r1_col_hold: assert property (@(posedge clk) disable iff (rst)
        (sel_col && $past(sel_col)) |-> $stable(dram_addr));

endmodule

// File: rtl/fpm_rd_capture.sv
module fpm_rd_capture #(
    parameter int DQ_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sample,
    input  logic            op_we,
    input  logic [DQ_W-1:0] dram_dq_in,
    output logic            host_ack,
    output logic [DQ_W-1:0] host_rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            host_ack   <= 1'b0;
            host_rdata <= '0;
        end else begin
            host_ack <= sample;
            if (sample && !op_we) begin
                host_rdata <= dram_dq_in;
            end
        end
    end

    // R2: acknowledge is a single-cycle pulse
    a_r2_ack_single: assert property (@(posedge clk) disable iff (rst)
        host_ack |=> !host_ack);

endmodule

// File: rtl/fpm_seq.sv
module fpm_seq
    import fpm_pkg::*;
#(
    parameter int T_ASR     = 1,
    parameter int T_RCD     = 3,
    parameter int T_ASC     = 1,
    parameter int T_CASL    = 2,
    parameter int T_CPX     = 1,
    parameter int T_RAC     = 6,
    parameter int T_RP      = 4,
    parameter int T_RAS_MIN = 6,
    parameter int T_RAS_MAX = 1250
) (
    input  logic clk,
    input  logic rst,
    input  logic host_req,
    input  logic close_req,
    input  logic row_hit,
    input  logic op_we,
    output logic accept,
    output logic sample,
    output logic sel_col,
    output logic drive_dq,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic oe_n,
    output logic idle
);
    localparam int SHORT_MAX = imax(imax(imax(T_ASR, T_RCD), imax(T_ASC, T_CASL)),
                                    imax(imax(T_CPX, T_RP), T_RAC));
    localparam int CW        = $clog2(SHORT_MAX + 1) + 1;
    localparam int RW        = $clog2(T_RAS_MAX + 1) + 1;
    localparam int ACC_LEN   = T_ASC + T_CASL + T_CPX;
    localparam int BUDGET    = T_RAS_MAX - ACC_LEN - 2;

    fpm_state_e      state, nxt;
    logic [CW-1:0]   cnt;
    logic [RW-1:0]   ras_lo;
    logic            ras_low;
    logic            want_close;

    always_comb begin
        nxt        = state;
        accept     = 1'b0;
        sample     = 1'b0;
        want_close = close_req || (ras_lo >= RW'(BUDGET)) || (host_req && !row_hit);
        unique case (state)
            ST_IDLE: begin
                if (host_req && !close_req) begin
                    accept = 1'b1;
                    nxt    = ST_RSET;
                end
            end
            ST_RSET: if (cnt >= CW'(T_ASR - 1)) nxt = ST_RCD;
            ST_RCD:  if (cnt >= CW'(T_RCD - 1)) nxt = ST_CSET;
            ST_CSET: if (cnt >= CW'(T_ASC - 1)) nxt = ST_CAS;
            ST_CAS: begin
                if (cnt >= CW'(T_CASL - 1) && ras_lo >= RW'(T_RAC - 1)) begin
                    sample = 1'b1;
                    nxt    = ST_CPRE;
                end
            end
            ST_CPRE: if (cnt >= CW'(T_CPX - 1)) nxt = ST_OPEN;
            ST_OPEN: begin
                if (want_close) begin
                    if (ras_lo >= RW'(T_RAS_MIN - 1)) nxt = ST_PRE;
                end else if (host_req) begin
                    accept = 1'b1;
                    nxt    = ST_CSET;
                end
            end
            ST_PRE: begin
                if (cnt >= CW'(T_RP - 1)) begin
                    if (host_req && !close_req) begin
                        accept = 1'b1;
                        nxt    = ST_RSET;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            ras_lo <= '0;
        end else begin
            state <= nxt;
            if (nxt != state) begin
                cnt <= '0;
            end else if (cnt != '1) begin
                cnt <= cnt + 1'b1;
            end
            if (!ras_low) begin
                ras_lo <= '0;
            end else if (ras_lo != '1) begin
                ras_lo <= ras_lo + 1'b1;
            end
        end
    end

    always_comb begin
        ras_low  = (state == ST_RCD)  || (state == ST_CSET) || (state == ST_CAS) ||
                   (state == ST_CPRE) || (state == ST_OPEN);
        sel_col  = (state == ST_CSET) || (state == ST_CAS) || (state == ST_CPRE);
        ras_n    = !ras_low;
        cas_n    = (state != ST_CAS);
        we_n     = !(op_we && sel_col);
        oe_n     = !(!op_we && (state == ST_CAS));
        drive_dq = op_we && sel_col;
        idle     = (state == ST_IDLE);
    end

    // Strobe high-time trackers used only by the checks below.
    logic [CW-1:0] ras_hi;
    logic [CW-1:0] cas_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_hi <= CW'(T_RP);
            cas_hi <= CW'(T_CPX);
        end else begin
            ras_hi <= ras_n ? ((ras_hi >= CW'(T_RP))  ? ras_hi : ras_hi + 1'b1) : '0;
            cas_hi <= cas_n ? ((cas_hi >= CW'(T_CPX)) ? cas_hi : cas_hi + 1'b1) : '0;
        end
    end

    // R3: precharge completed before the row strobe falls again
    a_r3_precharge: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (ras_hi >= CW'(T_RP)));

    // R4: column strobe falls only inside an open row
    a_r4_cas_in_row: assert property (@(posedge clk) disable iff (rst)
        $fell(cas_n) |-> !ras_n);

    // R5: column precharge gap respected
    a_r5_cas_gap: assert property (@(posedge clk) disable iff (rst)
        $fell(cas_n) |-> (cas_hi >= CW'(T_CPX)));

    // R7: row strobe low time bounded
    a_r7_ras_max: assert property (@(posedge clk) disable iff (rst)
        !ras_n |-> (ras_lo < RW'(T_RAS_MAX)));

    // R8: output enable stays inactive whenever write data is driven
    a_r8_write_oe: assert property (@(posedge clk) disable iff (rst)
        drive_dq |-> oe_n);

    // R9: read cycles keep write enable high before the column strobe
    a_r9_read_we: assert property (@(posedge clk) disable iff (rst)
        ($fell(cas_n) && !op_we) |-> $past(we_n));

    // R10: no row opens while the refresh block holds the DRAM idle
    a_r10_close_hold: assert property (@(posedge clk) disable iff (rst)
        (close_req && idle) |=> ras_n);

endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
    import fpm_pkg::*;
#(
    parameter int ROW_W       = 13,
    parameter int COL_W       = 11,
    parameter int DQ_W        = 4,
    parameter int CLK_PS      = 8000,
    parameter int TASR_NS     = 0,
    parameter int TRCD_NS     = 18,
    parameter int TASC_NS     = 0,
    parameter int TCAS_NS     = 12,
    parameter int TAA_NS      = 23,
    parameter int TRAC_NS     = 45,
    parameter int TCP_NS      = 8,
    parameter int TPC_NS      = 31,
    parameter int TRP_NS      = 25,
    parameter int TRAS_MIN_NS = 45,
    parameter int TRAS_MAX_NS = 10000
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   host_req,
    input  logic                   host_we,
    input  logic [ROW_W+COL_W-1:0] host_addr,
    input  logic [DQ_W-1:0]        host_wdata,
    output logic                   host_ack,
    output logic [DQ_W-1:0]        host_rdata,
    input  logic                   close_req,
    output logic                   idle,
    output logic                   dram_ras_n,
    output logic                   dram_cas_n,
    output logic                   dram_we_n,
    output logic                   dram_oe_n,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
    input  logic [DQ_W-1:0]        dram_dq_in,
    output logic [DQ_W-1:0]        dram_dq_out,
    output logic                   dram_dq_oe
);
    localparam int PA_W   = imax(ROW_W, COL_W);
    localparam int C_ASR  = ns2cyc(TASR_NS, CLK_PS);
    localparam int C_RCD  = ns2cyc(TRCD_NS, CLK_PS);
    localparam int C_ASC  = ns2cyc(TASC_NS, CLK_PS);
    localparam int C_CASL = imax(ns2cyc(TCAS_NS, CLK_PS), ns2cyc(TAA_NS, CLK_PS) - C_ASC);
    localparam int C_CPX  = imax(ns2cyc(TCP_NS, CLK_PS), ns2cyc(TPC_NS, CLK_PS) - C_ASC - C_CASL);
    localparam int C_RAC  = ns2cyc(TRAC_NS, CLK_PS);
    localparam int C_RP   = ns2cyc(TRP_NS, CLK_PS);
    localparam int C_RMIN = ns2cyc(TRAS_MIN_NS, CLK_PS);
    localparam int C_RMAX = (TRAS_MAX_NS * 1000) / CLK_PS;

    logic accept, sample, sel_col, drive_dq, row_hit, op_we;

    fpm_seq #(
        .T_ASR(C_ASR), .T_RCD(C_RCD), .T_ASC(C_ASC), .T_CASL(C_CASL),
        .T_CPX(C_CPX), .T_RAC(C_RAC), .T_RP(C_RP),
        .T_RAS_MIN(C_RMIN), .T_RAS_MAX(C_RMAX)
    ) u_seq (
        .clk(clk), .rst(rst), .host_req(host_req), .close_req(close_req),
        .row_hit(row_hit), .op_we(op_we), .accept(accept), .sample(sample),
        .sel_col(sel_col), .drive_dq(drive_dq), .ras_n(dram_ras_n),
        .cas_n(dram_cas_n), .we_n(dram_we_n), .oe_n(dram_oe_n), .idle(idle)
    );

    fpm_addr_path #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W), .PA_W(PA_W)
    ) u_addr (
        .clk(clk), .rst(rst), .accept(accept), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .sel_col(sel_col),
        .drive_dq(drive_dq), .row_hit(row_hit), .op_we(op_we),
        .dram_addr(dram_addr), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe)
    );

    fpm_rd_capture #(
        .DQ_W(DQ_W)
    ) u_cap (
        .clk(clk), .rst(rst), .sample(sample), .op_we(op_we),
        .dram_dq_in(dram_dq_in), .host_ack(host_ack), .host_rdata(host_rdata)
    );

endmodule

// File: tb/sim_fpm_dram_ctrl.sv
`timescale 1ns/1ps
module sim_fpm_dram_ctrl;
    localparam int ROW_W = 13;
    localparam int COL_W = 11;
    localparam int PA_W  = 13;
    // Cycle limits at 8 ns, worked out by hand from the requirements.
    localparam int TRCD = 3, TRAC = 6, TCAS = 2, TCP = 1, TPC = 4;
    localparam int TRP = 4, TRASMIN = 6, TRASMAX = 1250;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic                   host_req = 1'b0;
    logic                   host_we = 1'b0;
    logic [ROW_W+COL_W-1:0] host_addr = '0;
    logic [3:0]             host_wdata = '0;
    logic                   close_req = 1'b0;
    logic                   host_ack, idle;
    logic [3:0]             host_rdata;
    logic                   dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [PA_W-1:0]        dram_addr;
    logic [3:0]             dram_dq_out;
    logic [3:0]             m_dq = 4'h0;

    fpm_dram_ctrl u0 (
        .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
        .host_rdata(host_rdata), .close_req(close_req), .idle(idle),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_oe_n(dram_oe_n), .dram_addr(dram_addr), .dram_dq_in(m_dq),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe)
    );

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // ---------------- DRAM model ----------------
    logic [3:0] mem [int];
    logic [3:0] shadow [int];
    int  ras_falls = 0;
    int  m_ras_lo = 0, m_ras_hi = 100, m_cas_lo = 0, m_cas_hi = 100, m_since = 0;
    bit  m_ras_prev = 1, m_cas_prev = 1, m_we_prev = 1, m_have_cas = 0;
    logic [PA_W-1:0]  m_addr_prev = '0;
    logic [ROW_W-1:0] m_row = '0;
    logic [COL_W-1:0] m_col = '0;

    function automatic logic [3:0] mrd(input int k);
        return mem.exists(k) ? mem[k] : 4'h5;
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            if (!dram_ras_n && m_ras_prev) begin
                chk(m_ras_hi >= TRP, "R3 precharge", m_ras_hi, TRP);
                chk(dram_addr == m_addr_prev, "R1 row setup", dram_addr, m_addr_prev);
                m_row = dram_addr[ROW_W-1:0];
                m_ras_lo = 1;
                m_have_cas = 0;
                ras_falls++;
            end else if (!dram_ras_n) begin
                m_ras_lo++;
                if (m_ras_lo <= TRCD)
                    chk(dram_addr[ROW_W-1:0] == m_row, "R1 row hold", dram_addr, m_row);
            end else if (!m_ras_prev) begin
                chk(m_ras_lo >= TRASMIN, "R3 ras min", m_ras_lo, TRASMIN);
                chk(m_ras_lo <= TRASMAX, "R7 ras max", m_ras_lo, TRASMAX);
                m_ras_hi = 1;
            end else begin
                m_ras_hi++;
            end

            m_since++;
            if (!dram_cas_n && m_cas_prev) begin
                chk(!dram_ras_n, "R4 cas in row", dram_ras_n, 0);
                chk(m_cas_hi >= TCP, "R5 cas precharge", m_cas_hi, TCP);
                if (m_have_cas) chk(m_since >= TPC, "R5 page cycle", m_since, TPC);
                chk(dram_addr == m_addr_prev, "R1 col setup", dram_addr, m_addr_prev);
                m_col = dram_addr[COL_W-1:0];
                m_have_cas = 1;
                m_since = 0;
                m_cas_lo = 1;
                if (!dram_we_n) begin
                    chk(!m_we_prev, "R8 we setup", m_we_prev, 0);
                    chk(dram_dq_oe && dram_oe_n, "R8 dq drive oe high", {dram_dq_oe, dram_oe_n}, 3);
                    mem[int'({m_row, m_col})] = dram_dq_out;
                end else begin
                    chk(m_we_prev, "R9 we high", m_we_prev, 1);
                    chk(!dram_dq_oe, "R9 no drive", dram_dq_oe, 0);
                end
            end else if (!dram_cas_n) begin
                m_cas_lo++;
            end else if (!m_cas_prev) begin
                m_cas_hi = 1;
            end else begin
                m_cas_hi++;
            end

            if (!dram_cas_n && !dram_ras_n && m_cas_lo >= TCAS && m_ras_lo >= TRAC)
                m_dq <= mrd(int'({m_row, m_col}));
            else
                m_dq <= ~mrd(int'({m_row, m_col}));
        end
        m_ras_prev  = dram_ras_n;
        m_cas_prev  = dram_cas_n;
        m_we_prev   = dram_we_n;
        m_addr_prev = dram_addr;
    end

    // ---------------- scoreboard ----------------
    typedef struct { bit rd; logic [3:0] d; } exp_t;
    exp_t q [$];

    always @(negedge clk) begin
        if (!rst && host_ack) begin
            if (q.size() == 0) begin
                chk(0, "R2 unexpected ack", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (e.rd) chk(host_rdata == e.d, "R2 read data", host_rdata, e.d);
            end
        end
    end

    task automatic push_exp(input bit we, input int key, input logic [3:0] d);
        exp_t e;
        e.rd = !we;
        if (we) begin
            shadow[key] = d;
            e.d = d;
        end else begin
            e.d = shadow.exists(key) ? shadow[key] : 4'h5;
        end
        q.push_back(e);
    endtask

    task automatic access(input bit we, input int row, input int col, input logic [3:0] d);
        push_exp(we, int'({row[ROW_W-1:0], col[COL_W-1:0]}), d);
        @(negedge clk);
        host_req   = 1'b1;
        host_we    = we;
        host_addr  = {row[ROW_W-1:0], col[COL_W-1:0]};
        host_wdata = d;
        do @(negedge clk); while (!host_ack);
        host_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        int f0;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R11 strobes",
            {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
        chk(!dram_dq_oe && !host_ack, "R11 drive/ack", {dram_dq_oe, host_ack}, 0);
        chk(idle, "R11 idle", idle, 1);
        rst = 1'b0;

        // R4: page burst of writes then reads in one row
        f0 = ras_falls;
        for (int i = 0; i < 4; i++) access(1, 5, 3 + i, 4'(4'hA + i));
        for (int i = 0; i < 4; i++) access(0, 5, 3 + i, 4'h0);
        chk(ras_falls == f0 + 1, "R4 single open", ras_falls - f0, 1);
        repeat (2) @(negedge clk);
        chk(!idle && !dram_ras_n, "R10 busy while open", idle, 0);

        // R6: row changes and address boundaries
        f0 = ras_falls;
        access(1, 9, 2047, 4'h3);
        access(1, 8191, 0, 4'hC);
        access(0, 9, 2047, 4'h0);
        access(0, 8191, 0, 4'h0);
        access(0, 5, 4, 4'h0);
        chk(ras_falls == f0 + 5, "R6 row switches", ras_falls - f0, 5);

        // R10: refresh block closes the row and holds requests off
        access(0, 3, 1, 4'h0);
        @(negedge clk);
        close_req = 1'b1;
        repeat (TRP + 4) @(negedge clk);
        chk(idle && dram_ras_n, "R10 closed idle", {idle, dram_ras_n}, 3);
        f0 = ras_falls;
        push_exp(0, int'({13'd5, 11'd3}), 4'h0);
        host_req = 1'b1; host_we = 1'b0; host_addr = {13'd5, 11'd3};
        repeat (20) @(negedge clk);
        chk(ras_falls == f0 && dram_ras_n && idle, "R10 request held", ras_falls - f0, 0);
        close_req = 1'b0;
        do @(negedge clk); while (!host_ack);
        host_req = 1'b0;

        // R7: an idle open row must close by itself
        access(1, 7, 7, 4'h6);
        repeat (1300) @(negedge clk);
        chk(dram_ras_n && idle, "R7 idle row closed", {dram_ras_n, idle}, 3);

        // mixed traffic
        for (int i = 0; i < 40; i++)
            access((i % 3) != 2, 20 + ((i * 7) % 4), (i * 37) % 2048, 4'(i ^ 9));
        for (int i = 0; i < 40; i++)
            access(0, 20 + ((i * 7) % 4), (i * 37) % 2048, 4'h0);
        access(0, 7, 7, 4'h0);

        repeat (10) @(negedge clk);
        chk(q.size() == 0, "R2 all acked", q.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule